// File: doc/BRIEF.md
# Trigonometric argument range reducer

This block prepares an IEEE-754 double for sine or cosine evaluation when the argument may be very large. It multiplies the 53-bit significand by a 128-bit window taken from the binary expansion of 2/pi. It throws away every whole turn of the circle and keeps the two bits that name the quadrant. The remaining fraction of a quarter turn is left-normalized and returned as a fixed-point value together with the shift that was applied. The top few bits of the fraction, taken before normalization, are returned as an index that a later polynomial stage uses to pick its segment.

The expansion of 2/pi is computed when the design is elaborated and held as a constant long enough for the largest finite exponent. The block works on one operand at a time. A valid/ready pair takes the operand in, and a second valid/ready pair hands the result out. The product is formed over two cycles from a single 64x64 multiplier. Small arguments, zeros and subnormals skip the multiply. Infinities and NaNs are flagged as invalid.

Top module: `trig_arg_reducer`

## Requirements
- R1: Let E be the biased exponent minus 1023. The window start is k = 8*floor((E-54)/8) when E >= 54, otherwise k = 0. The multiplier operand S is expansion bits k+1 .. k+128, where bit 1 is the first bit after the binary point and the earliest bit is the most significant. Bits past the end of the stored expansion read as zero. Every finite exponent up to 1023 yields a valid, non-invalid result.
- R2: For a reduced operand, let d = E-52-k and P = M*S, where M is the significand with its hidden bit. The value P*2^(d-128) is taken modulo 4. Its two integer bits drive out_quad.
- R3: F is the 128-bit fraction of that value. Let z be the number of leading zeros of F, capped at 63. out_shift = z, and out_frac holds the top 64 bits of F shifted left by z. Whenever out_shift < 63, bit 63 of out_frac is one.
- R4: out_seg equals the top 4 bits of F, taken before normalization.
- R5: When the magnitude bits (bits 62..0) are below 0x3FE921FB54442D18, the operand bypasses the multiply. This covers zero and subnormal inputs. The result has out_pass=1, out_quad=0, out_shift=0 and out_seg=0. out_frac holds the hidden bit (1 only when the exponent field is nonzero) and the 52 mantissa bits in bits 63..11, with zeros below.
- R6: An exponent field of all ones (infinity or NaN) gives out_invalid=1, out_pass=0, and zero in out_quad, out_frac, out_shift and out_seg.
- R7: The reduction acts on the magnitude. out_sign carries bit 63 of the accepted operand.
- R8: Count the accepting clock edge as edge 1. out_valid is high after edge 5 for a reduced operand and after edge 1 for a bypassed or invalid one. Neither latency reaches 20 edges.
- R9: An operand is taken only on an edge where in_valid and in_ready are both high. in_ready falls after the accepting edge and stays low until the result has been taken. in_valid and in_data are ignored while in_ready is low.
- R10: While out_valid is high and out_ready is low, out_valid stays high and every result output holds its value.
- R11: After reset, in_ready is 1 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Block can take an operand |
| in_data | input | 64 | IEEE-754 double operand |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_quad | output | 2 | Quadrant number |
| out_frac | output | FRAC_W (64) | Normalized reduced fraction, or the passed-through significand |
| out_shift | output | clog2(SH_MAX+1) (6) | Left shift applied during normalization |
| out_seg | output | SEG_W (4) | Polynomial segment index |
| out_pass | output | 1 | Operand took the bypass path |
| out_invalid | output | 1 | Operand was an infinity or NaN |
| out_sign | output | 1 | Sign of the operand |

## Verification
The embedded properties rely on the consumer alone deciding when a result leaves. They also rely on in_data and in_valid mattering only on the edge where in_ready is high. The stability property therefore restricts the design only during cycles in which out_ready is held low. The bench changes in_valid, in_data and out_ready between clock edges, never on them. It offers new operands only when in_ready is high, except in one scenario that offers a different operand on purpose while the block is busy to show that the offer is ignored. Expected results come from a 256-bit prefix of 2/pi that the bench holds, so reduced operands are chosen with exponents no larger than 189. The largest finite exponent is checked only for validity and latency.

// File: rtl/trig_arg_reducer.sv
module trig_arg_reducer #(
  parameter int FRAC_W = 64,
  parameter int SEG_W  = 4,
  parameter int SH_MAX = 63
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic [63:0]                     in_data,
  output logic                            out_valid,
  input  logic                            out_ready,
  output logic [1:0]                      out_quad,
  output logic [FRAC_W-1:0]               out_frac,
  output logic [$clog2(SH_MAX+1)-1:0]     out_shift,
  output logic [SEG_W-1:0]                out_seg,
  output logic                            out_pass,
  output logic                            out_invalid,
  output logic                            out_sign
);

  localparam int EXP_TOP = 1023;
  localparam int SL_W    = 128;
  localparam int HALF    = SL_W / 2;
  localparam int PP_W    = 2 * HALF;
  localparam int ACC_W   = SL_W + HALF;
  localparam int AL_W    = SL_W + 2;
  localparam int WIDE_W  = 2 * SL_W;
  localparam int SHW     = $clog2(SH_MAX + 1);
  localparam int CB      = ((EXP_TOP - 54) / 8) * 8 + SL_W;
  localparam int NB      = CB + 32;
  localparam int WW      = NB + CB + 8;
  localparam logic [62:0] QUARTER_PI = 63'h3FE921FB54442D18;

  function automatic logic [CB-1:0] two_over_pi();
    logic [WW-1:0] t, term, p5, n5, p2, n2, pis, num;
    p5 = '0; n5 = '0; p2 = '0; n2 = '0;
    t = (WW'(1) << NB) / WW'(5);
    for (int k = 0; k < NB / 4; k++) begin
      term = t / WW'(2 * k + 1);
      if (k % 2 == 0) p5 = p5 + term;
      else            n5 = n5 + term;
      t = t / WW'(25);
    end
    t = (WW'(1) << NB) / WW'(239);
    for (int k = 0; k < NB / 14; k++) begin
      term = t / WW'(2 * k + 1);
      if (k % 2 == 0) p2 = p2 + term;
      else            n2 = n2 + term;
      t = t / WW'(57121);
    end
    pis = ((p5 - n5) << 4) - ((p2 - n2) << 2);
    num = WW'(1) << (NB + CB + 1);
    return CB'(num / pis);
  endfunction

  localparam logic [CB-1:0]      TWO_PI = two_over_pi();
  localparam logic [CB+SL_W-1:0] TPX    = {TWO_PI, {SL_W{1'b0}}};

  typedef enum logic [2:0] {ST_IDLE, ST_MUL0, ST_MUL1, ST_ALIGN, ST_NORM, ST_DONE} st_t;
  st_t state;

  logic [52:0]        sig_q;
  logic [SL_W-1:0]    slice_q;
  logic [5:0]         sh_q;
  logic [ACC_W-1:0]   acc_q;
  logic [SL_W-1:0]    fr_q;
  logic [1:0]         o_quad;
  logic [FRAC_W-1:0]  o_frac;
  logic [SHW-1:0]     o_shift;
  logic [SEG_W-1:0]   o_seg;
  logic               o_pass, o_inv, o_sign;

  logic               is_spec, is_small, hid;
  int                 e_in, k_in, sh_in;
  logic [SL_W-1:0]    slice_in;

  assign is_spec  = &in_data[62:52];
  assign is_small = in_data[62:0] < QUARTER_PI;
  assign hid      = |in_data[62:52];

  always_comb begin
    e_in     = int'(in_data[62:52]) - EXP_TOP;
    k_in     = (e_in >= 54) ? ((e_in - 54) / 8) * 8 : 0;
    sh_in    = e_in + 1 - k_in;
    slice_in = TPX[CB+SL_W-1-k_in -: SL_W];
  end

  logic [HALF-1:0] mul_b;
  logic [PP_W-1:0] pp;
  assign mul_b = (state == ST_MUL0) ? slice_q[HALF-1:0] : slice_q[SL_W-1:HALF];
  assign pp    = PP_W'(sig_q) * PP_W'(mul_b);

  logic [AL_W-1:0] al;
  assign al = AL_W'((WIDE_W'(acc_q) << sh_q) >> 53);

  logic [SHW-1:0] lz;
  logic           hit;
  always_comb begin
    lz  = SHW'(SH_MAX);
    hit = 1'b0;
    for (int i = 0; i <= SH_MAX; i++) begin
      if (!hit && fr_q[SL_W-1-i]) begin
        lz  = SHW'(i);
        hit = 1'b1;
      end
    end
  end

  logic [FRAC_W-1:0] nf;
  assign nf = FRAC_W'((fr_q << lz) >> (SL_W - FRAC_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sig_q   <= '0;
      slice_q <= '0;
      sh_q    <= '0;
      acc_q   <= '0;
      fr_q    <= '0;
      o_quad  <= '0;
      o_frac  <= '0;
      o_shift <= '0;
      o_seg   <= '0;
      o_pass  <= 1'b0;
      o_inv   <= 1'b0;
      o_sign  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          o_sign <= in_data[63];
          if (is_spec) begin
            o_inv   <= 1'b1;
            o_pass  <= 1'b0;
            o_quad  <= '0;
            o_frac  <= '0;
            o_shift <= '0;
            o_seg   <= '0;
            state   <= ST_DONE;
          end else if (is_small) begin
            o_inv   <= 1'b0;
            o_pass  <= 1'b1;
            o_quad  <= '0;
            o_frac  <= FRAC_W'({hid, in_data[51:0]}) << (FRAC_W - 53);
            o_shift <= '0;
            o_seg   <= '0;
            state   <= ST_DONE;
          end else begin
            o_inv   <= 1'b0;
            o_pass  <= 1'b0;
            sig_q   <= {1'b1, in_data[51:0]};
            slice_q <= slice_in;
            sh_q    <= 6'(sh_in);
            state   <= ST_MUL0;
          end
        end
        ST_MUL0: begin
          acc_q <= ACC_W'(pp);
          state <= ST_MUL1;
        end
        ST_MUL1: begin
          acc_q <= acc_q + {pp, {HALF{1'b0}}};
          state <= ST_ALIGN;
        end
        ST_ALIGN: begin
          o_quad <= al[AL_W-1 -: 2];
          fr_q   <= al[SL_W-1:0];
          state  <= ST_NORM;
        end
        ST_NORM: begin
          o_frac  <= nf;
          o_shift <= lz;
          o_seg   <= fr_q[SL_W-1 -: SEG_W];
          state   <= ST_DONE;
        end
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready    = (state == ST_IDLE);
  assign out_valid   = (state == ST_DONE);
  assign out_quad    = o_quad;
  assign out_frac    = o_frac;
  assign out_shift   = o_shift;
  assign out_seg     = o_seg;
  assign out_pass    = o_pass;
  assign out_invalid = o_inv;
  assign out_sign    = o_sign;

  logic [4:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else if (in_valid && in_ready) lat_q <= 5'd1;
    else if (!in_ready && !out_valid && lat_q != 5'd31) lat_q <= lat_q + 5'd1;
  end

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> lat_q < 5'd20);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_frac) && $stable(out_quad)
      && $stable(out_shift) && $stable(out_seg) && $stable(out_pass)
      && $stable(out_invalid) && $stable(out_sign));

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  p_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> out_quad == 2'd0 && out_frac == '0 && !out_pass);

  p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_pass |-> out_quad == 2'd0 && out_shift == '0 && out_seg == '0);

  p_norm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_pass && !out_invalid && out_shift != SHW'(SH_MAX) |-> out_frac[FRAC_W-1]);

  p_seg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_pass && !out_invalid && out_shift == '0
      |-> out_seg == out_frac[FRAC_W-1 -: SEG_W]);

endmodule

// File: tb/sim_trig_arg_reducer.sv
module sim_trig_arg_reducer;
  localparam logic [255:0] C =
    256'hA2F9836E4E441529FC2757D1F534DDC0DB6295993C439041FE5163ABDEBBC561;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [63:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [1:0] out_quad;
  logic [63:0] out_frac;
  logic [5:0] out_shift;
  logic [3:0] out_seg;
  logic out_pass, out_invalid, out_sign;

  int vecs = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trig_arg_reducer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_quad(out_quad), .out_frac(out_frac),
    .out_shift(out_shift), .out_seg(out_seg), .out_pass(out_pass),
    .out_invalid(out_invalid), .out_sign(out_sign)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [63:0] x, output logic [1:0] q,
                                output logic [63:0] fr, output logic [5:0] sh,
                                output logic [3:0] sg);
    int e, k, d, z;
    logic [127:0] s, f;
    logic [52:0] m;
    logic [511:0] p, v;
    e = int'(x[62:52]) - 1023;
    k = (e >= 54) ? ((e - 54) / 8) * 8 : 0;
    s = C[255-k -: 128];
    m = {1'b1, x[51:0]};
    p = 512'(m) * 512'(s);
    d = e - 52 - k;
    v = (p << 256) >> (128 - d);
    q = v[257:256];
    f = v[255:128];
    z = 63;
    for (int i = 63; i >= 0; i--) if (f[127-i]) z = i;
    sh = 6'(z);
    fr = 64'((f << z) >> 64);
    sg = f[127:124];
  endfunction

  task automatic send(input logic [63:0] x, output int lat);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data = x;
    @(posedge clk);
    #1 in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 40) begin
      @(posedge clk);
      #1 lat++;
    end
  endtask

  task automatic pop();
    out_ready = 1'b1;
    @(posedge clk);
    #1 out_ready = 1'b0;
  endtask

  task automatic expect_reduced(input string tag, input logic [63:0] x);
    logic [1:0] q; logic [63:0] fr; logic [5:0] sh; logic [3:0] sg;
    int lat;
    model(x, q, fr, sh, sg);
    send(x, lat);
    check({tag, " R8 latency"}, 128'(lat), 128'(5));
    check({tag, " R2 quadrant"}, 128'(out_quad), 128'(q));
    check({tag, " R3 fraction"}, 128'(out_frac), 128'(fr));
    check({tag, " R3 shift"}, 128'(out_shift), 128'(sh));
    check({tag, " R4 segment"}, 128'(out_seg), 128'(sg));
    check({tag, " R7 sign"}, 128'(out_sign), 128'(x[63]));
    check({tag, " R5 R6 flags"}, 128'({out_pass, out_invalid}), 128'(0));
    pop();
  endtask

  task automatic t_reset();
    #1;
    check("R11 in_ready in reset", 128'(in_ready), 128'(1));
    check("R11 out_valid in reset", 128'(out_valid), 128'(0));
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R11 in_ready after reset", 128'(in_ready), 128'(1));
    check("R11 out_valid after reset", 128'(out_valid), 128'(0));
  endtask

  task automatic t_literal();
    int lat;
    send(64'h3FF0000000000000, lat);
    check("R2 x=1 quadrant", 128'(out_quad), 128'(0));
    check("R3 x=1 fraction", 128'(out_frac), 128'(64'hA2F9836E4E441529));
    check("R3 x=1 shift", 128'(out_shift), 128'(0));
    check("R4 x=1 segment", 128'(out_seg), 128'(4'hA));
    pop();
    send(64'h4000000000000000, lat);
    check("R2 x=2 quadrant", 128'(out_quad), 128'(1));
    check("R3 x=2 fraction", 128'(out_frac), 128'(64'h8BE60DB9391054A7));
    check("R3 x=2 shift", 128'(out_shift), 128'(1));
    check("R4 x=2 segment", 128'(out_seg), 128'(4'h4));
    pop();
  endtask

  task automatic t_sweep();
    expect_reduced("R2 x=3", 64'h4008000000000000);
    expect_reduced("R2 x=10.5", 64'h4025000000000000);
    expect_reduced("R2 x=1e6", 64'h412E848000000000);
    expect_reduced("R7 x=-5", 64'hC014000000000000);
    expect_reduced("R5 x=pi/4 not bypassed", 64'h3FE921FB54442D18);
    expect_reduced("R3 x just above pi/2", 64'h3FF921FB54442D19);
    expect_reduced("R1 E=100", 64'h4634CCCCCCCCCCCD);
    expect_reduced("R1 E=150", 64'h4950123456789ABC);
    expect_reduced("R1 E=189", 64'h4BCFEDCBA9876543);
  endtask

  task automatic bypass_one(input string tag, input logic [63:0] x, input logic [63:0] fr);
    int lat;
    send(x, lat);
    check({tag, " R8 latency"}, 128'(lat), 128'(1));
    check({tag, " R5 pass"}, 128'(out_pass), 128'(1));
    check({tag, " R5 quad/shift/seg"}, 128'({out_quad, out_shift, out_seg}), 128'(0));
    check({tag, " R5 fraction"}, 128'(out_frac), 128'(fr));
    check({tag, " R7 sign"}, 128'(out_sign), 128'(x[63]));
    pop();
  endtask

  task automatic t_bypass();
    bypass_one("R5 x=0.5", 64'h3FE0000000000000, 64'h8000000000000000);
    bypass_one("R5 x=-0.25", 64'hBFD0000000000000, 64'h8000000000000000);
    bypass_one("R5 zero", 64'h0000000000000000, 64'h0);
    bypass_one("R5 subnormal", 64'h000000000000000F, 64'h0000000000007800);
  endtask

  task automatic special_one(input string tag, input logic [63:0] x);
    int lat;
    send(x, lat);
    check({tag, " R8 latency"}, 128'(lat), 128'(1));
    check({tag, " R6 flags"}, 128'({out_invalid, out_pass}), 128'(2'b10));
    check({tag, " R6 zero result"}, 128'({out_quad, out_frac, out_shift, out_seg}), 128'(0));
    pop();
  endtask

  task automatic t_special();
    special_one("R6 +inf", 64'h7FF0000000000000);
    special_one("R6 NaN", 64'h7FF8000000000000);
    special_one("R6 -inf", 64'hFFF0000000000000);
  endtask

  task automatic t_max();
    int lat;
    send(64'h7FEFFFFFFFFFFFFF, lat);
    check("R1 largest finite latency R8", 128'(lat), 128'(5));
    check("R1 largest finite flags", 128'({out_invalid, out_pass}), 128'(0));
    pop();
  endtask

  task automatic t_hold();
    logic [1:0] q; logic [63:0] fr; logic [5:0] sh; logic [3:0] sg;
    int lat;
    model(64'h4025000000000000, q, fr, sh, sg);
    send(64'h4025000000000000, lat);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
    end
    check("R10 valid held", 128'(out_valid), 128'(1));
    check("R10 fraction held", 128'(out_frac), 128'(fr));
    check("R10 quadrant held", 128'(out_quad), 128'(q));
    check("R9 no accept while result waits", 128'(in_ready), 128'(0));
    pop();
    check("R10 valid drops once taken", 128'(out_valid), 128'(0));
  endtask

  task automatic t_busy();
    logic [1:0] q; logic [63:0] fr; logic [5:0] sh; logic [3:0] sg;
    int lat;
    model(64'h4008000000000000, q, fr, sh, sg);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = 64'h4008000000000000;
    @(posedge clk);
    #1 in_data = 64'h7FF0000000000000;
    check("R9 in_ready low after accept", 128'(in_ready), 128'(0));
    lat = 1;
    while (!out_valid && lat < 40) begin
      @(posedge clk);
      #1 lat++;
    end
    in_valid = 1'b0;
    check("R9 busy offer ignored latency", 128'(lat), 128'(5));
    check("R9 busy offer ignored fraction", 128'(out_frac), 128'(fr));
    check("R9 busy offer ignored flags", 128'({out_invalid, out_pass}), 128'(0));
    pop();
    check("R9 in_ready back after result taken", 128'(in_ready), 128'(1));
    expect_reduced("R9 next operand", 64'h412E848000000000);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    vecs++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    t_reset();
    t_literal();
    t_sweep();
    t_bypass();
    t_special();
    t_max();
    t_hold();
    t_busy();
    finish_run();
  end
endmodule